// File: doc/BRIEF.md
# Dual-Speed SCL Timing Generator

This block turns the system clock into the clock line of an I2C bus master, one bit period at a time. The byte sequencer raises a request whenever the block reports it is ready. The block then drives SCL low, runs a low phase, releases the line and waits until the line reads back high. After that it runs a high phase and reports that the bit is finished. Along the way it emits single-cycle strobes: SCL falling, the moment SDA may change, SCL rising, the sample point and bit completion.

Each speed has its own pair of 16-bit phase counts, and a two-bit speed field chooses between them. Two 8-bit counts space the SDA change after the falling edge (hold) and ahead of the next rising edge (setup). All timing inputs are captured when a bit is accepted and stay fixed for that whole bit. Counts too small to be legal are raised to a floor. Slaves may stretch the clock by holding SCL low after the master releases it. The control registers that feed the timing inputs sit outside this block; the package records their reset values: standard 0x264 high and 0x2C2 low, fast 0x6E high and 0xCF low, hold 1, setup 0x64.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is held and after it is released, sclRelease is 1 and bitReady is 1, and no event strobe is asserted.
- R2: A bitReq sampled while bitReady is 1 gives, in the next cycle, sclRelease 0 with evFall 1. A bitReq sampled while bitReady is 0 is ignored: no extra evFall appears, and once bitDone has pulsed the line stays released with bitReady 1.
- R3: speedSel 2'b10 selects fastHighCnt/fastLowCnt. Every other value (2'b01, 2'b00, 2'b11) selects stdHighCnt/stdLowCnt.
- R4: Let effLow be max(selected low count, 6), effHold be max(sdaHoldCnt, 1) and effSetup be max(sdaSetupCnt, 2). SCL is held low for exactly max(effLow, effHold + effSetup) cycles, counting the evFall cycle as cycle 0.
- R5: Let effHigh be max(selected high count, 6). The evRise cycle is index 0. evSample pulses once, at index effHigh/2 (rounded down). bitDone pulses once, at index effHigh-1. The five strobes are never asserted in the same cycle.
- R6: evSdaChange pulses once per bit, exactly effHold cycles after evFall; a hold count of 0 behaves as 1.
- R7: evRise comes at least effSetup cycles after evSdaChange; a setup count below 2 behaves as 2.
- R8: Once SCL is released, evRise stays low and the high count does not start until sclIn reads 1. Each cycle sclIn stays low delays evRise, evSample and bitDone by one cycle.
- R9: All timing inputs are captured in the cycle a bit is accepted; changing them later in that bit has no effect on it.
- R10: A bitReq presented in the bitDone cycle is accepted at once, so the next cycle is an evFall cycle with SCL low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitReq | input | 1 | Request one bit period; taken when bitReady is 1 |
| sclIn | input | 1 | SCL level read back from the bus |
| speedSel | input | 2 | Speed field: 2'b10 fast, anything else standard |
| stdHighCnt | input | 16 | Standard-speed high phase count |
| stdLowCnt | input | 16 | Standard-speed low phase count |
| fastHighCnt | input | 16 | Fast-speed high phase count |
| fastLowCnt | input | 16 | Fast-speed low phase count |
| sdaHoldCnt | input | 8 | Cycles from SCL fall to the SDA change point |
| sdaSetupCnt | input | 8 | Minimum cycles from the SDA change point to SCL rise |
| bitReady | output | 1 | A request is taken in this cycle |
| sclRelease | output | 1 | 1 releases SCL (open drain), 0 pulls it low |
| evFall | output | 1 | First cycle of SCL low |
| evSdaChange | output | 1 | SDA may be changed now |
| evRise | output | 1 | SCL seen high after release |
| evSample | output | 1 | Sample point in the high phase |
| bitDone | output | 1 | Last cycle of the bit period |

## Verification
Two things can fall in the same cycle: the end of one bit and the acceptance of the next. A bitReq is raised exactly in the bitDone cycle, and the check is that the very next cycle shows evFall with SCL low, with no idle cycle between the bits. The second pairing is acceptance and a change of timing inputs. The inputs present in the accept cycle are applied, then replaced at random a few cycles later. Every timestamp of that bit is compared with values computed from the captured inputs only.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  localparam logic [1:0] SPEED_STD  = 2'b01;
  localparam logic [1:0] SPEED_FAST = 2'b10;

  localparam int MIN_PHASE = 6;
  localparam int MIN_SETUP = 2;
  localparam int MIN_HOLD  = 1;

  // reset values of the external timing registers feeding this block
  localparam logic [15:0] RST_STD_HIGH  = 16'h0264;
  localparam logic [15:0] RST_STD_LOW   = 16'h02C2;
  localparam logic [15:0] RST_FAST_HIGH = 16'h006E;
  localparam logic [15:0] RST_FAST_LOW  = 16'h00CF;
  localparam logic [7:0]  RST_HOLD      = 8'h01;
  localparam logic [7:0]  RST_SETUP     = 8'h64;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_WAIT,
    ST_HIGH
  } sclState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCfg;
    logic cntClear;
    logic cntSetOne;
    logic cntInc;
  } dpCtl_t;

  // datapath -> control compare results
  typedef struct packed {
    logic holdHit;
    logic lowLast;
    logic sampleHit;
    logic highLast;
  } dpFlags_t;

endpackage

// File: rtl/scl_timing_dp.sv
module scl_timing_dp
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SDA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [1:0]       speedSel,
  input  logic [CNT_W-1:0] stdHighCnt,
  input  logic [CNT_W-1:0] stdLowCnt,
  input  logic [CNT_W-1:0] fastHighCnt,
  input  logic [CNT_W-1:0] fastLowCnt,
  input  logic [SDA_W-1:0] sdaHoldCnt,
  input  logic [SDA_W-1:0] sdaSetupCnt,
  output dpFlags_t         flags
);

  localparam int CW = CNT_W + 1;

  logic          useFast;
  logic [CW-1:0] rawHigh, rawLow, effHigh, effLow;
  logic [CW-1:0] effHold, effSetup, holdSetup, lowSpan;
  logic [CW-1:0] highLat, lowSpanLat, holdLat;
  logic [CW-1:0] cnt;

  always_comb begin
    useFast   = (speedSel == SPEED_FAST);
    rawHigh   = CW'(useFast ? fastHighCnt : stdHighCnt);
    rawLow    = CW'(useFast ? fastLowCnt : stdLowCnt);
    effHigh   = (rawHigh < CW'(MIN_PHASE)) ? CW'(MIN_PHASE) : rawHigh;
    effLow    = (rawLow < CW'(MIN_PHASE)) ? CW'(MIN_PHASE) : rawLow;
    effHold   = (CW'(sdaHoldCnt) < CW'(MIN_HOLD)) ? CW'(MIN_HOLD) : CW'(sdaHoldCnt);
    effSetup  = (CW'(sdaSetupCnt) < CW'(MIN_SETUP)) ? CW'(MIN_SETUP) : CW'(sdaSetupCnt);
    holdSetup = effHold + effSetup;
    lowSpan   = (effLow > holdSetup) ? effLow : holdSetup;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highLat    <= CW'(RST_STD_HIGH);
      lowSpanLat <= CW'(RST_STD_LOW);
      holdLat    <= CW'(RST_HOLD);
    end else if (ctl.loadCfg) begin
      highLat    <= effHigh;
      lowSpanLat <= lowSpan;
      holdLat    <= effHold;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (ctl.cntClear)  cnt <= '0;
    else if (ctl.cntSetOne) cnt <= CW'(1);
    else if (ctl.cntInc)    cnt <= cnt + CW'(1);
  end

  always_comb begin
    flags.holdHit   = (cnt == holdLat);
    flags.lowLast   = (cnt == lowSpanLat - CW'(1));
    flags.sampleHit = (cnt == (highLat >> 1));
    flags.highLast  = (cnt == highLat - CW'(1));
  end

  // R9: captured timing only moves on an accept
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadCfg |=> ($stable(highLat) && $stable(lowSpanLat) && $stable(holdLat)));

endmodule

// File: rtl/scl_timing_ctl.sv
module scl_timing_ctl
  import scl_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitReq,
  input  logic     sclIn,
  input  dpFlags_t flags,
  output dpCtl_t   ctl,
  output logic     bitReady,
  output logic     sclRelease,
  output logic     evFall,
  output logic     evSdaChange,
  output logic     evRise,
  output logic     evSample,
  output logic     bitDone
);

  sclState_e st, stNext;
  logic      accept, fallPend, lowPhase, waitPhase, highPhase;

  always_comb begin
    lowPhase   = (st == ST_LOW);
    waitPhase  = (st == ST_WAIT);
    highPhase  = (st == ST_HIGH);
    bitDone    = highPhase && flags.highLast;
    bitReady   = (st == ST_IDLE) || bitDone;
    accept     = bitReady && bitReq;
    sclRelease = !lowPhase;
    evFall     = fallPend;
    evSdaChange = lowPhase && flags.holdHit;
    evRise     = waitPhase && sclIn;
    evSample   = highPhase && flags.sampleHit;
  end

  always_comb begin
    stNext = st;
    unique case (st)
      ST_IDLE: if (accept) stNext = ST_LOW;
      ST_LOW:  if (flags.lowLast) stNext = ST_WAIT;
      ST_WAIT: if (sclIn) stNext = ST_HIGH;
      ST_HIGH: if (flags.highLast) stNext = accept ? ST_LOW : ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.loadCfg   = accept;
    ctl.cntClear  = accept || (lowPhase && flags.lowLast);
    ctl.cntSetOne = waitPhase && sclIn;
    ctl.cntInc    = lowPhase || highPhase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      fallPend <= 1'b0;
    end else begin
      st       <= stNext;
      fallPend <= accept;
    end
  end

  // R2: a request while busy never starts a bit
  a_r2_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!bitReady && bitReq) |=> !evFall);

  // R6: the SDA change point never shares the falling-edge cycle
  a_r6_hold_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    evFall |-> !evSdaChange);

  // R8: a stretched line keeps the block waiting with SCL released
  a_r8_stretch_wait: assert property (@(posedge clk) disable iff (!rstN)
    (waitPhase && !sclIn) |=> (waitPhase && sclRelease && !evSample));

  // R5: strobes are mutually exclusive
  a_r5_events_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evFall, evSdaChange, evRise, evSample, bitDone}));

  // R10: request in the last cycle chains straight into a fall
  a_r10_chain: assert property (@(posedge clk) disable iff (!rstN)
    (bitDone && bitReq) |=> (evFall && !sclRelease));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SDA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitReq,
  input  logic             sclIn,
  input  logic [1:0]       speedSel,
  input  logic [CNT_W-1:0] stdHighCnt,
  input  logic [CNT_W-1:0] stdLowCnt,
  input  logic [CNT_W-1:0] fastHighCnt,
  input  logic [CNT_W-1:0] fastLowCnt,
  input  logic [SDA_W-1:0] sdaHoldCnt,
  input  logic [SDA_W-1:0] sdaSetupCnt,
  output logic             bitReady,
  output logic             sclRelease,
  output logic             evFall,
  output logic             evSdaChange,
  output logic             evRise,
  output logic             evSample,
  output logic             bitDone
);

  dpCtl_t   ctlBus;
  dpFlags_t flagBus;

  scl_timing_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .bitReq     (bitReq),
    .sclIn      (sclIn),
    .flags      (flagBus),
    .ctl        (ctlBus),
    .bitReady   (bitReady),
    .sclRelease (sclRelease),
    .evFall     (evFall),
    .evSdaChange(evSdaChange),
    .evRise     (evRise),
    .evSample   (evSample),
    .bitDone    (bitDone)
  );

  scl_timing_dp #(
    .CNT_W(CNT_W),
    .SDA_W(SDA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctlBus),
    .speedSel   (speedSel),
    .stdHighCnt (stdHighCnt),
    .stdLowCnt  (stdLowCnt),
    .fastHighCnt(fastHighCnt),
    .fastLowCnt (fastLowCnt),
    .sdaHoldCnt (sdaHoldCnt),
    .sdaSetupCnt(sdaSetupCnt),
    .flags      (flagBus)
  );

endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitReq = 1'b0;
  logic        holdLow = 1'b0;
  logic [1:0]  speedSel = 2'b01;
  logic [15:0] stdHighCnt = 16'd0, stdLowCnt = 16'd0, fastHighCnt = 16'd0, fastLowCnt = 16'd0;
  logic [7:0]  sdaHoldCnt = 8'd0, sdaSetupCnt = 8'd0;
  logic        bitReady, sclRelease, evFall, evSdaChange, evRise, evSample, bitDone;
  logic        sclIn;
  int          total = 0;
  int          bad = 0;

  always #2 clk = ~clk;

  assign sclIn = sclRelease && !holdLow;

  scl_timing_gen i_scl_timing_gen (
    .clk(clk), .rstN(rstN), .bitReq(bitReq), .sclIn(sclIn), .speedSel(speedSel),
    .stdHighCnt(stdHighCnt), .stdLowCnt(stdLowCnt),
    .fastHighCnt(fastHighCnt), .fastLowCnt(fastLowCnt),
    .sdaHoldCnt(sdaHoldCnt), .sdaSetupCnt(sdaSetupCnt),
    .bitReady(bitReady), .sclRelease(sclRelease), .evFall(evFall),
    .evSdaChange(evSdaChange), .evRise(evRise), .evSample(evSample), .bitDone(bitDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int atLeast(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  task automatic runBit(input int sh, input int sl, input int fh, input int fl,
                        input int hold, input int setup, input logic [1:0] spd,
                        input int nStretch, input bit midChange, input bit midReq,
                        input bit chained, input bit chainNext);
    bit useFast = (spd == 2'b10);
    int eh = atLeast(useFast ? fh : sh, 6);
    int el = atLeast(useFast ? fl : sl, 6);
    int eHold = atLeast(hold, 1);
    int eSet = atLeast(setup, 2);
    int span = (el > eHold + eSet) ? el : eHold + eSet;
    int expRise = span + nStretch;
    int tRel = -1, tH = -1, tR = -1, tS = -1, tD = -1;
    int cH = 0, cR = 0, cS = 0, cF = 0, relSeen = 0;
    stdHighCnt = 16'(sh); stdLowCnt = 16'(sl);
    fastHighCnt = 16'(fh); fastLowCnt = 16'(fl);
    sdaHoldCnt = 8'(hold); sdaSetupCnt = 8'(setup); speedSel = spd;
    chk(bitReady, chained ? "R10" : "R2", int'(bitReady), 1);
    bitReq = 1'b1;
    @(negedge clk);
    bitReq = 1'b0;
    holdLow = 1'b0;
    #1;
    chk(evFall && !sclRelease, chained ? "R10" : "R2", int'({evFall, sclRelease}), 2);
    for (int t = 1; t < 70000 && tD < 0; t++) begin
      @(negedge clk);
      if (sclRelease && relSeen < nStretch) begin
        holdLow = 1'b1;
        relSeen++;
      end else holdLow = 1'b0;
      bitReq = midReq && (t == 3);
      if (midChange && t == 2) begin
        stdHighCnt = 16'($urandom_range(0, 90)); stdLowCnt = 16'($urandom_range(0, 90));
        fastHighCnt = 16'($urandom_range(0, 90)); fastLowCnt = 16'($urandom_range(0, 90));
        sdaHoldCnt = 8'($urandom_range(0, 40)); sdaSetupCnt = 8'($urandom_range(0, 40));
        speedSel = 2'($urandom_range(0, 3));
      end
      #1;
      if (sclRelease && tRel < 0) tRel = t;
      if (evFall) cF++;
      if (evSdaChange) begin cH++; if (tH < 0) tH = t; end
      if (evRise) begin cR++; if (tR < 0) tR = t; end
      if (evSample) begin cS++; if (tS < 0) tS = t; end
      if (bitDone) tD = t;
    end
    bitReq = chainNext;
    holdLow = 1'b0;
    chk(tRel == span, "R4", tRel, span);
    chk(tH == eHold && cH == 1, "R6", tH, eHold);
    chk(tR == expRise && cR == 1, "R8", tR, expRise);
    chk(tR - tH >= eSet, "R7", tR - tH, eSet);
    chk(tS == expRise + eh / 2 && cS == 1, "R5", tS, expRise + eh / 2);
    chk(tD == expRise + eh - 1, midChange ? "R9" : "R3", tD, expRise + eh - 1);
    chk(cF == 0, "R2", cF, 0);
  endtask

  task automatic idleCheck();
    @(negedge clk);
    #1;
    chk(sclRelease && bitReady && !evFall, "R2", int'({sclRelease, bitReady, evFall}), 6);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk(sclRelease && bitReady && !(evFall | evSdaChange | evRise | evSample | bitDone),
          "R1", int'({sclRelease, bitReady}), 3);
    end
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(sclRelease && bitReady && !evFall, "R1", int'({sclRelease, bitReady}), 3);

    // register reset timing, standard then fast
    runBit(16'h264, 16'h2C2, 16'h6E, 16'hCF, 1, 16'h64, 2'b01, 0, 0, 0, 0, 0);
    idleCheck();
    runBit(16'h264, 16'h2C2, 16'h6E, 16'hCF, 1, 16'h64, 2'b10, 0, 0, 0, 0, 0);
    idleCheck();
    // floors on all counts, R3 other speed codes
    runBit(3, 0, 5, 2, 0, 0, 2'b00, 0, 0, 0, 0, 0);
    idleCheck();
    runBit(9, 7, 40, 40, 0, 1, 2'b11, 0, 0, 1, 0, 0);
    idleCheck();
    // setup+hold longer than the low count
    runBit(8, 6, 8, 6, 10, 30, 2'b01, 0, 0, 0, 0, 0);
    idleCheck();
    // stretching
    runBit(12, 10, 7, 7, 2, 3, 2'b10, 7, 0, 0, 0, 0);
    idleCheck();
    // R10 chain of three with config change at accept
    runBit(10, 10, 6, 6, 1, 2, 2'b01, 0, 1, 0, 0, 1);
    runBit(20, 9, 6, 8, 4, 2, 2'b10, 1, 1, 0, 1, 1);
    runBit(7, 15, 30, 30, 3, 5, 2'b01, 0, 0, 0, 1, 0);
    idleCheck();

    for (int n = 0; n < 40; n++) begin
      bit chainNext = ($urandom_range(0, 2) == 0);
      runBit($urandom_range(0, 60), $urandom_range(0, 60), $urandom_range(0, 60),
             $urandom_range(0, 60), $urandom_range(0, 30), $urandom_range(0, 30),
             2'($urandom_range(0, 3)), $urandom_range(0, 5),
             $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 0, 0);
      if (chainNext)
        runBit($urandom_range(0, 60), $urandom_range(0, 60), $urandom_range(0, 60),
               $urandom_range(0, 60), $urandom_range(0, 30), $urandom_range(0, 30),
               2'($urandom_range(0, 3)), 0, 0, 0, 0, 0);
      idleCheck();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule